// File: doc/BRIEF.md
# Reference Clock Lock Indicator

This block tells downstream logic whether a clock multiplier is following its reference. It watches two clocks that are asynchronous to its own free-running monitor clock: the reference itself, and a divided-down copy of the generated clock. Both are brought into the monitor domain through synchronizers. Their rising edges are then counted over a fixed window of monitor cycles.

At the close of every window the block sorts the two edge counts into one of three cases and drives a single output.

- **Reference absent** (stuck high or stuck low): the output is held low.
- **Counts agree** within a tolerance set on an input port: the output is held high.
- **Counts disagree**: the output inverts once per window, which forms a square pulse train.

A system can therefore tell a dead reference from a loop that has lost frequency lock by looking only at whether the pin is steady or toggling.

Top module: `lkd_lock_detect`

## Requirements
- R1: While reset is asserted, and until the first window closes after reset is released, `lock_o` is 0.
- R2: When the reference and divided clocks produce equal rising-edge counts in a window, `lock_o` is 1 for the following window.
- R3: When the absolute difference between the two counts is no greater than `tol_i`, `lock_o` is 1. This holds even if the frequencies are not identical.
- R4: A reference held at 0 for a whole window gives zero reference edges and drives `lock_o` to 0.
- R5: A reference held at 1 for a whole window is also treated as absent and drives `lock_o` to 0.
- R6: When the reference is present and the count difference exceeds `tol_i`, `lock_o` inverts at every window close. The output is therefore high for one window in two.
- R7: `lock_o` changes only on the monitor clock edge that immediately follows the edge ending a window. It is constant for the rest of the window.
- R8: A reference that is present while the divided clock is stopped is reported as a mismatch (toggling), not as an absent reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon_i | input | 1 | Free-running monitor clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to the monitor clock |
| fb_clk_i | input | 1 | Divided copy of the generated clock, asynchronous |
| tol_i | input | CNT_W (7) | Largest edge-count difference still accepted as locked |
| lock_o | output | 1 | Lock indicator: high, low or toggling |

## Verification
The bench targets the three-way split at the window boundary.

- **Stuck-high reference (R5):** a design that looked only for a low level would call it present. It would then toggle or report lock instead of holding low.
- **Stopped divided clock (R8):** a design that tested the wrong counter for zero would hold the output low instead of toggling.
- **Tolerance boundary (R3, R6):** the same offset clocks are run against a tolerance above and below their count difference. This exposes a comparison that is off by one or reversed.
- **Window timing (R7):** the output is sampled both in the middle and at the very end of each window. This catches a design that lets the output change anywhere other than the window close.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    // Classification of one completed measurement window
    typedef enum logic [1:0] {
        LK_ABSENT = 2'd0,
        LK_LOCKED = 2'd1,
        LK_SLIP   = 2'd2
    } lk_state_e;

    // Number of clock channels under measurement: reference and feedback
    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_REF = 0;
    localparam int unsigned CH_FB  = 1;

endpackage

// File: rtl/lkd_edge_sync.sv
module lkd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              last;
        logic              rise;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[STAGES-2:0], async_i};
        s_d.last = s_q.pipe[STAGES-1];
        s_d.rise = s_q.pipe[STAGES-1] & ~s_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.rise;
endmodule

// File: rtl/lkd_window.sv
module lkd_window #(
    parameter int unsigned WIN_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned WW = $clog2(WIN_CYCLES);
    localparam logic [WW-1:0] LAST = WW'(WIN_CYCLES - 1);

    typedef struct packed {
        logic [WW-1:0] cnt;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (w_q.cnt == LAST) w_d.cnt = '0;
        else                 w_d.cnt = w_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign tick_o = (w_q.cnt == LAST);
endmodule

// File: rtl/lkd_edge_counter.sv
module lkd_edge_counter #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] snap_o,
    output logic             vld_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] snap;
        logic             vld;
    } ctr_t;

    ctr_t c_d, c_q;
    logic [CNT_W-1:0] inc;

    always_comb begin
        c_d = c_q;
        // Saturating add of this cycle's edge
        if (rise_i && (c_q.run != CMAX)) inc = c_q.run + 1'b1;
        else                             inc = c_q.run;
        c_d.vld = tick_i;
        if (tick_i) begin
            c_d.snap = inc;
            c_d.run  = '0;
        end else begin
            c_d.run  = inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign snap_o = c_q.snap;
    assign vld_o  = c_q.vld;
endmodule

// File: rtl/lkd_classifier.sv
module lkd_classifier
    import lkd_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [CNT_W-1:0] ref_cnt_i,
    input  logic [CNT_W-1:0] fb_cnt_i,
    input  logic [CNT_W-1:0] tol_i,
    output logic             lock_o
);
    typedef struct packed {
        lk_state_e state;
        logic      out;
    } cls_t;

    cls_t k_d, k_q;
    logic [CNT_W-1:0] diff;

    always_comb begin
        k_d = k_q;
        if (ref_cnt_i >= fb_cnt_i) diff = ref_cnt_i - fb_cnt_i;
        else                       diff = fb_cnt_i - ref_cnt_i;
        if (vld_i) begin
            if (ref_cnt_i == '0) begin
                k_d.state = LK_ABSENT;
                k_d.out   = 1'b0;
            end else if (diff <= tol_i) begin
                k_d.state = LK_LOCKED;
                k_d.out   = 1'b1;
            end else begin
                k_d.state = LK_SLIP;
                k_d.out   = ~k_q.out;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '{state: LK_ABSENT, out: 1'b0};
        else        k_q <= k_d;
    end

    assign lock_o = k_q.out;
endmodule

// File: rtl/lkd_lock_detect.sv
module lkd_lock_detect
    import lkd_pkg::*;
#(
    parameter int unsigned WIN_CYCLES  = 64,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = $clog2(WIN_CYCLES) + 1
) (
    input  logic             clk_mon_i,
    input  logic             rst_n_i,
    input  logic             ref_clk_i,
    input  logic             fb_clk_i,
    input  logic [CNT_W-1:0] tol_i,
    output logic             lock_o
);
    logic [NUM_CH-1:0] ch_in;
    logic [NUM_CH-1:0] ch_rise;
    logic [NUM_CH-1:0] ch_vld;
    logic [CNT_W-1:0]  ch_snap [NUM_CH];
    logic              tick;
    logic              snap_vld;
    logic [CNT_W-1:0]  ref_cnt;
    logic [CNT_W-1:0]  fb_cnt;

    assign ch_in[CH_REF] = ref_clk_i;
    assign ch_in[CH_FB]  = fb_clk_i;

    lkd_window #(.WIN_CYCLES(WIN_CYCLES)) i_window (
        .clk    (clk_mon_i),
        .rst_n  (rst_n_i),
        .tick_o (tick)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        lkd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk     (clk_mon_i),
            .rst_n   (rst_n_i),
            .async_i (ch_in[g]),
            .rise_o  (ch_rise[g])
        );
        lkd_edge_counter #(.CNT_W(CNT_W)) i_cnt (
            .clk    (clk_mon_i),
            .rst_n  (rst_n_i),
            .rise_i (ch_rise[g]),
            .tick_i (tick),
            .snap_o (ch_snap[g]),
            .vld_o  (ch_vld[g])
        );
    end

    assign snap_vld = &ch_vld;
    assign ref_cnt  = ch_snap[CH_REF];
    assign fb_cnt   = ch_snap[CH_FB];

    lkd_classifier #(.CNT_W(CNT_W)) i_cls (
        .clk       (clk_mon_i),
        .rst_n     (rst_n_i),
        .vld_i     (snap_vld),
        .ref_cnt_i (ref_cnt),
        .fb_cnt_i  (fb_cnt),
        .tol_i     (tol_i),
        .lock_o    (lock_o)
    );
endmodule

// File: rtl/lkd_lock_checker.sv
module lkd_lock_checker #(
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             snap_vld,
    input logic [CNT_W-1:0] ref_cnt,
    input logic [CNT_W-1:0] fb_cnt,
    input logic [CNT_W-1:0] tol,
    input logic             lock
);
    p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !lock)
        else $error("R1 lock high after reset cycle");

    p_hold_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_vld |=> $stable(lock))
        else $error("R7 lock changed away from window close");

    p_absent_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_vld && ref_cnt == '0) |=> !lock)
        else $error("R4 absent reference not reported low");

    p_equal_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_vld && ref_cnt != '0 && ref_cnt == fb_cnt) |=> lock)
        else $error("R2 equal counts not reported high");

    p_fb_stopped_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_vld && ref_cnt != '0 && fb_cnt == '0 && ref_cnt > tol)
        |=> (lock != $past(lock)))
        else $error("R8 stopped feedback not reported as toggling");
endmodule

bind lkd_lock_detect lkd_lock_checker #(.CNT_W(CNT_W)) i_lock_checker (
    .clk      (clk_mon_i),
    .rst_n    (rst_n_i),
    .snap_vld (snap_vld),
    .ref_cnt  (ref_cnt),
    .fb_cnt   (fb_cnt),
    .tol      (tol_i),
    .lock     (lock_o)
);

// File: tb/test_lkd_lock_detect.sv
module test_lkd_lock_detect;
    localparam int WIN   = 64;
    localparam int CNT_W = $clog2(WIN) + 1;

    typedef enum {EX_SKIP, EX_HIGH, EX_LOW, EX_TOGGLE} ex_kind_e;
    typedef struct {
        ex_kind_e kind;
        string    tag;
    } ex_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_clk = 1'b0;
    logic             fb_clk = 1'b0;
    logic [CNT_W-1:0] tol = '0;
    logic             lock;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // stimulus control: half period in monitor cycles, 0 = stuck at level
    int ref_half = 0;
    int fb_half = 0;
    logic ref_lvl = 1'b0;
    logic fb_lvl = 1'b0;
    int ref_ph = 0;
    int fb_ph = 0;

    ex_item_t exp_q[$];

    always #10 clk = ~clk;

    lkd_lock_detect #(.WIN_CYCLES(WIN)) i_lkd_lock_detect (
        .clk_mon_i (clk),
        .rst_n_i   (rst_n),
        .ref_clk_i (ref_clk),
        .fb_clk_i  (fb_clk),
        .tol_i     (tol),
        .lock_o    (lock)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // clock sources, changed away from the monitor edge
    always @(negedge clk) begin
        if (ref_half == 0) ref_clk = ref_lvl;
        else begin
            ref_ph = ref_ph + 1;
            if (ref_ph >= ref_half) begin ref_ph = 0; ref_clk = ~ref_clk; end
        end
        if (fb_half == 0) fb_clk = fb_lvl;
        else begin
            fb_ph = fb_ph + 1;
            if (fb_ph >= fb_half) begin fb_ph = 0; fb_clk = ~fb_clk; end
        end
    end

    task automatic check(input bit ok, input string tag, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: lock_o=%0b expected %0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_boundary();
        @(negedge clk);
        while (cyc % WIN != 0) @(negedge clk);
    endtask

    task automatic run_phase(input int rh, input logic rl, input int fh, input logic fl,
                             input int t, input ex_kind_e kind, input int n, input string tag);
        wait_boundary();
        ref_half = rh; ref_lvl = rl; fb_half = fh; fb_lvl = fl; tol = CNT_W'(t);
        exp_q.push_back('{EX_SKIP, tag});
        exp_q.push_back('{EX_SKIP, tag});
        for (int i = 0; i < n; i++) exp_q.push_back('{kind, tag});
        for (int i = 0; i < n + 1; i++) wait_boundary();
    endtask

    // monitor / scoreboard
    initial begin
        logic     prev = 1'b0;
        logic     mid_val = 1'b0;
        bit       mid_ok = 0;
        ex_item_t it;
        logic     expv;
        forever begin
            @(negedge clk);
            if (rst_n && cyc > 0 && cyc % WIN == 0 && mid_ok) begin
                check(lock === mid_val, "R7 stable to window end", lock, mid_val);
                mid_ok = 0;
            end
            if (rst_n && cyc % WIN == WIN / 2 && exp_q.size() > 0) begin
                it = exp_q.pop_front();
                case (it.kind)
                    EX_HIGH:   expv = 1'b1;
                    EX_LOW:    expv = 1'b0;
                    EX_TOGGLE: expv = ~prev;
                    default:   expv = lock;
                endcase
                if (it.kind != EX_SKIP) check(lock === expv, it.tag, lock, expv);
                mid_val = lock;
                mid_ok = (it.kind != EX_SKIP);
                prev = lock;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(lock === 1'b0, "R1 during reset", lock, 1'b0);
        rst_n = 1'b1;
        ref_half = 2; fb_half = 2; tol = CNT_W'(1);
        repeat (20) @(negedge clk);
        check(lock === 1'b0, "R1 before first window close", lock, 1'b0);
        // matched clocks
        run_phase(2, 1'b0, 2, 1'b0, 1,  EX_HIGH,   4, "R2 matched");
        // offset clocks (about 16 vs 8 edges), tolerance too small
        run_phase(2, 1'b0, 4, 1'b0, 6,  EX_TOGGLE, 4, "R6 offset beyond tolerance");
        // same offset, tolerance covers it
        run_phase(2, 1'b0, 4, 1'b0, 12, EX_HIGH,   3, "R3 offset within tolerance");
        // reference stuck low
        run_phase(0, 1'b0, 2, 1'b0, 1,  EX_LOW,    3, "R4 reference stuck low");
        // recover, then reference stuck high
        run_phase(2, 1'b0, 2, 1'b0, 1,  EX_HIGH,   2, "R2 recovery");
        run_phase(0, 1'b1, 2, 1'b0, 1,  EX_LOW,    3, "R5 reference stuck high");
        // reference running, divided clock stopped
        run_phase(2, 1'b0, 0, 1'b0, 1,  EX_TOGGLE, 4, "R8 divided clock stopped");
        run_phase(2, 1'b0, 2, 1'b0, 1,  EX_HIGH,   2, "R2 final");
        wait_boundary();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule